// File: doc/BRIEF.md
# Divider Setting Loader for a Programmable Clock Synthesizer

This block holds the feedback-divider value (M) and the output-divider value (N) of a programmable clock synthesizer. It also decides where those values come from. A parallel path copies them from input buses. A serial path assembles them in a 12-bit shift register and then moves them to the outputs. A serial-direct test path shifts bits straight into the M value and shows each bit on a TEST observation output.

Two strobes select the source. The parallel load strobe is active low. While it is low the block is transparent, and its rising edge captures the buses. The serial load strobe acts on its level and on both of its edges. The load strobes, the serial clock and the serial data are asynchronous pins. Each one passes through a two-flop synchronizer in the system clock domain, and its edges are found by comparing the current synchronized sample with the previous one. The master reset, the parallel buses and the system reset are sampled directly.

Top module: `divcfg_loader`

## Requirements
- R1: While `mr` is high at a clock edge, `m_out`, `n_out` and `test_out` are 0 after that edge and the shift register is cleared. This overrides every other input.
- R2: While the synchronized `pl_n` is low, each edge copies `m_in`/`n_in` to `m_out`/`n_out` and drives `test_out` to 0.
- R3: A synchronized rising edge of `pl_n` captures `m_in`/`n_in`. The captured value holds through later changes on `m_in`/`n_in` until `pl_n` goes low again or a serial load event occurs.
- R4: With `pl_n` high and `sl` low, each synchronized rising edge of `sck` shifts `sd` into bit 0 of the 12-bit shift register, and the older bits move one place up. `m_out`/`n_out` do not change.
- R5: A synchronized rising edge of `sl` loads `n_out` from shift bits [11:9] and `m_out` from bits [8:0], and drives `test_out` to 0. Because bits are shifted in MSB first, the first three bits form N and the last nine form M.
- R6: A synchronized falling edge of `sl` keeps `m_out`/`n_out` at their present values and drives `test_out` to 0.
- R7: While `sl` is high, each synchronized rising edge of `sck` sets `m_out` to its lower 8 bits followed by `sd`. `n_out` and the shift register are not altered by this.
- R8: `test_out` equals the `sd` bit most recently shifted in the direct mode while `sl` stays high. It is 0 in every other mode.
- R9: A change on `pl_n`, `sl`, `sck` or `sd` that is present at clock edge k acts on the outputs at edge k+2. A change on `mr`, `m_in` or `n_in` acts at edge k.
- R10: While `rst_n` is low at a clock edge, all outputs and the shift register are 0, and the synchronizers settle to `pl_n` high and the other pins low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| mr | input | 1 | Master reset, active high, clears the outputs |
| pl_n | input | 1 | Parallel load strobe, active low |
| m_in | input | 9 | Parallel M value |
| n_in | input | 3 | Parallel N value |
| sl | input | 1 | Serial load strobe |
| sck | input | 1 | Serial clock (asynchronous) |
| sd | input | 1 | Serial data |
| m_out | output | 9 | M feedback-divider value |
| n_out | output | 3 | N output-divider value |
| test_out | output | 1 | Serial-direct observation bit |

## Verification
A pin that passes through the synchronizers acts at the second clock edge after the edge that first samples it. `mr` and the parallel buses act at the first edge. The bench model keeps the last three sampled pin words in a queue and decides from the entries two and three edges old. The bench drives every input on the falling clock edge and compares the outputs with the model on every falling edge, half a cycle after the result settles. Directed checks wait several cycles after each strobe or serial-clock change, then read the values worked out by hand for serial transfer, direct shifting, capture and reset.

// File: rtl/divcfg_pkg.sv
// Shared definitions for the divider setting loader.
// Assumes the synchronized pin word is ordered {sd, sck, sl, pl_n}.
package divcfg_pkg;
    localparam int SYNC_W  = 4;
    localparam int IDX_PL  = 0;
    localparam int IDX_SL  = 1;
    localparam int IDX_SCK = 2;
    localparam int IDX_SD  = 3;

    typedef enum logic [2:0] {
        MODE_RESET,
        MODE_PASS,
        MODE_CAPTURE,
        MODE_XFER,
        MODE_HOLD,
        MODE_SHIFT,
        MODE_DIRECT,
        MODE_IDLE
    } cfg_mode_e;
endpackage

// File: rtl/cfgl_sync.sv
// Two-flop synchronizer with one extra history stage per bit.
// lvl is the synchronized level and prev is lvl one cycle earlier.
// Assumes every input bit is asynchronous to clk.
module cfgl_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    // Shift each pin through the metastability, level and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            lvl_q  <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= d;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl  = lvl_q;
    assign prev = prev_q;
endmodule

// File: rtl/cfgl_decode.sv
// Chooses the action for this cycle from the master reset and the
// synchronized levels and edges. Priority: reset, parallel transparent,
// parallel capture, serial transfer, serial latch, clock-edge shifting.
module cfgl_decode
    import divcfg_pkg::*;
(
    input  logic      mr,
    input  logic      pl,
    input  logic      pl_prev,
    input  logic      sl,
    input  logic      sl_prev,
    input  logic      ck,
    input  logic      ck_prev,
    output cfg_mode_e mode
);
    logic ck_rise;
    assign ck_rise = ck & ~ck_prev;

    // Priority decode of the active mode.
    always_comb begin
        if (mr)                    mode = MODE_RESET;
        else if (!pl)              mode = MODE_PASS;
        else if (!pl_prev)         mode = MODE_CAPTURE;
        else if (sl && !sl_prev)   mode = MODE_XFER;
        else if (!sl && sl_prev)   mode = MODE_HOLD;
        else if (ck_rise && !sl)   mode = MODE_SHIFT;
        else if (ck_rise && sl)    mode = MODE_DIRECT;
        else                       mode = MODE_IDLE;
    end
endmodule

// File: rtl/cfgl_shift.sv
// Serial shift register: the new bit enters at bit 0, older bits move up.
// clr empties it. Assumes en and clr are never high in the same cycle.
module cfgl_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_q;

    // Clear or shift by one position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh_q <= '0;
        else if (en)       sh_q <= {sh_q[W-2:0], din};
    end

    assign q = sh_q;
endmodule

// File: rtl/divcfg_loader.sv
// Divider setting loader: holds M and N and chooses where they come from
// (parallel buses, shift register, or direct serial test path).
// Assumes m_in/n_in are steady around parallel strobe edges; strobes,
// serial clock and data are asynchronous and synchronized here.
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mr,
    input  logic           pl_n,
    input  logic [M_W-1:0] m_in,
    input  logic [N_W-1:0] n_in,
    input  logic           sl,
    input  logic           sck,
    input  logic           sd,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic           test_out
);
    localparam int SH_W = M_W + N_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << IDX_PL;

    logic [SYNC_W-1:0] pin_word;
    logic [SYNC_W-1:0] sync_lvl;
    logic [SYNC_W-1:0] sync_prv;
    logic [SH_W-1:0]   sh_q;
    cfg_mode_e         mode;
    logic [M_W-1:0]    m_q;
    logic [N_W-1:0]    n_q;
    logic              t_q;

    assign pin_word = {sd, sck, sl, pl_n};

    cfgl_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_word),
        .lvl  (sync_lvl),
        .prev (sync_prv)
    );

    cfgl_decode u_dec (
        .mr     (mr),
        .pl     (sync_lvl[IDX_PL]),
        .pl_prev(sync_prv[IDX_PL]),
        .sl     (sync_lvl[IDX_SL]),
        .sl_prev(sync_prv[IDX_SL]),
        .ck     (sync_lvl[IDX_SCK]),
        .ck_prev(sync_prv[IDX_SCK]),
        .mode   (mode)
    );

    cfgl_shift #(.W(SH_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (mode == MODE_RESET),
        .en   (mode == MODE_SHIFT),
        .din  (sync_lvl[IDX_SD]),
        .q    (sh_q)
    );

    // Output registers updated according to the decoded mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
            t_q <= 1'b0;
        end else begin
            unique case (mode)
                MODE_RESET: begin
                    m_q <= '0;
                    n_q <= '0;
                    t_q <= 1'b0;
                end
                MODE_PASS, MODE_CAPTURE: begin
                    m_q <= m_in;
                    n_q <= n_in;
                    t_q <= 1'b0;
                end
                MODE_XFER: begin
                    m_q <= sh_q[M_W-1:0];
                    n_q <= sh_q[SH_W-1:M_W];
                    t_q <= 1'b0;
                end
                MODE_HOLD: t_q <= 1'b0;
                MODE_DIRECT: begin
                    m_q <= {m_q[M_W-2:0], sync_lvl[IDX_SD]};
                    t_q <= sync_lvl[IDX_SD];
                end
                default: ;
            endcase
        end
    end

    assign m_out    = m_q;
    assign n_out    = n_q;
    assign test_out = t_q;
endmodule

// File: rtl/divcfg_loader_chk.sv
// Property checker for divcfg_loader, attached by bind. Observes the ports
// and the synchronized strobe levels of the top module.
module divcfg_loader_chk #(
    parameter int M_W = 9,
    parameter int N_W = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mr,
    input logic [M_W-1:0] m_in,
    input logic [N_W-1:0] n_in,
    input logic [3:0]     sync_lvl,
    input logic [3:0]     sync_prv,
    input logic [M_W-1:0] m_out,
    input logic [N_W-1:0] n_out,
    input logic           test_out
);
    logic pl, plp, sl, slp;
    assign pl  = sync_lvl[0];
    assign plp = sync_prv[0];
    assign sl  = sync_lvl[1];
    assign slp = sync_prv[1];

    AST_MR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> (m_out == '0 && n_out == '0 && !test_out)); // R1
    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && !pl) |=> (m_out == $past(m_in) && n_out == $past(n_in) && !test_out)); // R2
    AST_SERIAL_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && pl && plp && !sl && !slp) |=> ($stable(m_out) && $stable(n_out))); // R4
    AST_XFER_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && pl && plp && sl && !slp) |=> !test_out); // R5
    AST_FALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && pl && plp && !sl && slp) |=> ($stable(m_out) && $stable(n_out))); // R6
    AST_DIRECT_N_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && pl && plp && sl && slp) |=> $stable(n_out)); // R7
    AST_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sl |=> !test_out); // R8
endmodule

bind divcfg_loader divcfg_loader_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mr      (mr),
    .m_in    (m_in),
    .n_in    (n_in),
    .sync_lvl(sync_lvl),
    .sync_prv(sync_prv),
    .m_out   (m_out),
    .n_out   (n_out),
    .test_out(test_out)
);

// File: tb/divcfg_loader_bench.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed checks with hand-computed values.
module divcfg_loader_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b0;
    logic       pl_n = 1'b1;
    logic [8:0] m_in = '0;
    logic [2:0] n_in = '0;
    logic       sl = 1'b0;
    logic       sck = 1'b0;
    logic       sd = 1'b0;
    logic [8:0] m_out;
    logic [2:0] n_out;
    logic       test_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    divcfg_loader u_divcfg_loader (
        .clk(clk), .rst_n(rst_n), .mr(mr), .pl_n(pl_n), .m_in(m_in),
        .n_in(n_in), .sl(sl), .sck(sck), .sd(sd), .m_out(m_out),
        .n_out(n_out), .test_out(test_out)
    );

    // Reference model: pins act two edges after first sampled (R9).
    logic [3:0]  hist[$];
    logic [8:0]  em = '0;
    logic [2:0]  en = '0;
    logic        et = 1'b0;
    logic [11:0] esh = '0;
    string       ereq = "R10";

    initial hist = '{4'b0001, 4'b0001, 4'b0001};

    always @(posedge clk) begin
        if (!rst_n) begin
            em = '0; en = '0; et = 1'b0; esh = '0; ereq = "R10";
            hist = '{4'b0001, 4'b0001, 4'b0001};
        end else begin
            logic [3:0] cur, old;
            cur = hist[1];
            old = hist[2];
            if (mr) begin
                em = '0; en = '0; et = 1'b0; esh = '0; ereq = "R1";
            end else if (!cur[0]) begin
                em = m_in; en = n_in; et = 1'b0; ereq = "R2";
            end else if (!old[0]) begin
                em = m_in; en = n_in; et = 1'b0; ereq = "R3";
            end else if (cur[1] && !old[1]) begin
                em = esh[8:0]; en = esh[11:9]; et = 1'b0; ereq = "R5";
            end else if (!cur[1] && old[1]) begin
                et = 1'b0; ereq = "R6";
            end else if (cur[2] && !old[2]) begin
                if (!cur[1]) begin
                    esh = {esh[10:0], cur[3]}; ereq = "R4";
                end else begin
                    em = {em[7:0], cur[3]}; et = cur[3]; ereq = "R7";
                end
            end
            hist.push_front({sd, sck, sl, pl_n});
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model, half a cycle after the edge.
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (m_out !== em || n_out !== en || test_out !== et) begin
                bad++;
                $display("FAIL %s: got m=%h n=%h t=%b expected m=%h n=%h t=%b",
                         ereq, m_out, n_out, test_out, em, en, et);
            end
        end
    end

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(string r, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic pulse_sck(bit b);
        sd = b; cyc(1);
        sck = 1'b1; cyc(4);
        sck = 1'b0; cyc(4);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R10", {m_out, n_out, test_out}, 0);
        rst_n = 1'b1;
        cyc(2);
        // R2: transparent
        pl_n = 1'b0; m_in = 9'h1FF; n_in = 3'd7; cyc(5);
        chk("R2", m_out, 9'h1FF); chk("R2", n_out, 7);
        m_in = 9'h0AA; n_in = 3'd1; cyc(1);
        chk("R2", m_out, 9'h0AA);
        // R3: capture then hold
        m_in = 9'h123; n_in = 3'd2; cyc(1);
        pl_n = 1'b1; cyc(6);
        m_in = 9'h0F0; n_in = 3'd6; cyc(4);
        chk("R3", m_out, 9'h123); chk("R3", n_out, 2);
        // R4: shift 12'hA5C MSB first, outputs unchanged
        for (int i = 11; i >= 0; i--) pulse_sck(1'((12'hA5C >> i) & 1));
        chk("R4", m_out, 9'h123);
        // R5: transfer
        sl = 1'b1; cyc(5);
        chk("R5", n_out, 5); chk("R5", m_out, 9'h05C); chk("R8", test_out, 0);
        // R7/R8: direct shifting
        pulse_sck(1'b1); chk("R8", test_out, 1);
        pulse_sck(1'b0); chk("R8", test_out, 0);
        pulse_sck(1'b1);
        chk("R7", m_out, 9'h0E5); chk("R7", n_out, 5); chk("R8", test_out, 1);
        // R6: falling edge holds, test low
        sl = 1'b0; cyc(5);
        chk("R6", m_out, 9'h0E5); chk("R8", test_out, 0);
        // R7: shift register untouched by direct mode
        sl = 1'b1; cyc(5);
        chk("R7", m_out, 9'h05C);
        sl = 1'b0; cyc(5);
        // R9: latency of a strobe
        pl_n = 1'b0; m_in = 9'h111; n_in = 3'd3;
        cyc(1); chk("R9", m_out, 9'h05C);
        cyc(1); chk("R9", m_out, 9'h05C);
        cyc(1); chk("R9", m_out, 9'h111);
        // R1: master reset overrides
        mr = 1'b1; cyc(1);
        chk("R1", {m_out, n_out, test_out}, 0);
        cyc(3); mr = 1'b0; pl_n = 1'b1; cyc(6);
        sl = 1'b1; cyc(5);
        chk("R1", {m_out, n_out}, 0);
        sl = 1'b0; cyc(5);
        // R10: system reset mid-run
        rst_n = 1'b0; cyc(2);
        chk("R10", {m_out, n_out, test_out}, 0);
        rst_n = 1'b1; cyc(4);
        finish_run();
    end
endmodule